// File: doc/BRIEF.md
# Codec Serial Frame Receiver

This block turns the serial input stream of an audio codec link back into parallel words. The codec shifts out one bit per bit-clock period. Each 256-bit frame opens with a 16-bit tag and is followed by twelve 20-bit slots. The block samples the data line on the falling edge of the bit clock. It tracks its position in the frame with a counter that returns to zero whenever the frame-sync signal rises.

From each frame the block keeps four things: the tag, the upper 16 bits of slot 2 (the value of a register that was requested in the previous outgoing frame), and the upper 18 bits of slots 3 and 4 (the left and right ADC samples, two's complement). A frame is complete once its last bit has been sampled. At that point the block publishes all of these words together and raises a one-cycle done strobe. Each word comes with a valid flag, which is built from the frame's ready bit and the tag bit for its slot. The published values then stay frozen until the next frame completes.

All logic runs on the falling edge of the bit clock and uses a synchronous active-low reset sampled on that edge.

Top module: `codec_frame_deser`

## Requirements
- R1: While reset is asserted and after its release, every output is zero and `frame_done` is low until a complete frame has been received.
- R2: Serial data is sampled on the falling edge of `bit_clk`. The bit sampled on the first falling edge at which `sync_in` is seen high, after having been seen low, is frame bit 0. Later bits follow in order, and frame bit 255 is the last.
- R3: `frame_tag` holds frame bits 0..15. Bit 0 lands in `frame_tag[15]` and bit 15 in `frame_tag[0]`.
- R4: `reg_data` holds the 16 most significant bits of slot 2, which are frame bits 36..51, MSB first. Frame bits 52..55 are discarded.
- R5: `left_pcm` holds frame bits 56..73, the upper 18 bits of slot 3. `right_pcm` holds frame bits 76..93, the upper 18 bits of slot 4. Both are MSB first and keep the sign bit in bit 17. The two low bits of each slot are discarded.
- R6: The valid flags use bit positions of the captured tag. `reg_valid` = `frame_tag[15]` AND `frame_tag[13]`. `left_valid` = `frame_tag[15]` AND `frame_tag[12]`. `right_valid` = `frame_tag[15]` AND `frame_tag[11]`.
- R7: The falling edge that samples frame bit 255 updates all data outputs and raises `frame_done` for exactly one bit-clock period.
- R8: Between two `frame_done` pulses, all data and valid outputs keep their values.
- R9: A rising edge on `sync_in` at any point restarts the frame at bit 0. A frame cut short this way produces no `frame_done`, and the frame that follows is decoded correctly.
- R10: After reset, no `frame_done` occurs until a rising edge of `sync_in` has been seen.
- R11: Once aligned, if no new sync rising edge arrives, the position wraps from bit 255 to bit 0. The next 256 bits are then decoded as a full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock from the codec; all logic uses its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Frame sync; its rising edge marks frame bit 0 |
| sdata_in | input | 1 | Serial data from the codec, MSB first |
| frame_tag | output | 16 | Tag of the last completed frame |
| reg_data | output | 16 | Register readback word from slot 2 |
| reg_valid | output | 1 | Slot 2 marked valid in a ready frame |
| left_pcm | output | 18 | Left ADC sample, two's complement |
| left_valid | output | 1 | Slot 3 marked valid in a ready frame |
| right_pcm | output | 18 | Right ADC sample, two's complement |
| right_valid | output | 1 | Slot 4 marked valid in a ready frame |
| frame_done | output | 1 | One-cycle strobe when new outputs are published |

## Verification
The bench sweeps all sixteen combinations of the ready bit and the three slot-valid bits. It uses slot contents derived from the sweep index, so an off-by-one in slot position, a wrong tag-bit mapping, or a missing ready gate shows up as wrong data or a wrong flag. Extreme samples (most positive and most negative 18-bit values, with the two dropped bits set) expose sign loss and failure to discard the low bits. A frame cut short by a new sync edge catches a counter that does not realign: such a design would emit a spurious strobe or decode the next frame shifted. A run of data with no sync after reset, and a frame sent with no sync at all, separate a design that counts before alignment from one that fails to wrap.

// File: rtl/cfd_pkg.sv
// Package: shared frame geometry for the codec frame receiver.
// Assumes a fixed 256-bit frame: 16-bit tag plus twelve 20-bit slots.
package cfd_pkg;
    localparam int TAG_W          = 16;
    localparam int SLOT_W         = 20;
    localparam int NUM_SLOTS      = 12;
    localparam int FRAME_W        = TAG_W + SLOT_W * NUM_SLOTS;
    localparam int IDX_W          = $clog2(FRAME_W);
    localparam int REG_W          = 16;
    localparam int PCM_W          = 18;
    localparam int REG_SLOT       = 2;
    localparam int FIRST_PCM_SLOT = 3;
    localparam int NUM_PCM        = 2;
    localparam int READY_BIT      = 15;
endpackage

// File: rtl/cfd_bit_index.sv
// Module: frame position tracker.
// Detects the rising edge of sync (sampled on the bit-clock falling edge),
// reports the index of the bit being sampled in the current cycle, and keeps
// a flag once alignment has been reached. Assumes sync is driven away from
// the falling edge.
module cfd_bit_index #(
    parameter int FRAME_W = cfd_pkg::FRAME_W,
    parameter int IDX_W   = cfd_pkg::IDX_W
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic [IDX_W-1:0] idx_now,
    output logic             aligned
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic             sync_q;
    logic             locked;
    logic [IDX_W-1:0] cnt;
    logic             sync_rise;

    // Rising edge of sync seen at this falling edge.
    assign sync_rise = sync_in & ~sync_q;
    // Current bit index: forced to zero on a sync rise.
    assign idx_now   = sync_rise ? '0 : cnt;
    // Aligned from the first sync rise onward.
    assign aligned   = locked | sync_rise;

    // Advance the position counter and remember sync history.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            locked <= 1'b0;
            cnt    <= '0;
        end else begin
            sync_q <= sync_in;
            locked <= aligned;
            if (aligned) begin
                cnt <= (idx_now == LAST_IDX) ? '0 : idx_now + IDX_W'(1);
            end
        end
    end

    AST_SYNC_REALIGN: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (sync_in && !sync_q) |=> (cnt == IDX_W'(1)));                 // R9
    AST_IDLE_BEFORE_SYNC: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !aligned |=> (cnt == '0));                                    // R10
endmodule

// File: rtl/cfd_slot_capture.sv
// Module: serial shifter and slot capture.
// Shifts data in MSB first and, at the last bit of the tag, of the register
// slot and of each audio slot, stores the wanted field into a holding
// register. Assumes idx_now names the bit sampled in this cycle.
module cfd_slot_capture #(
    parameter int TAG_W          = cfd_pkg::TAG_W,
    parameter int SLOT_W         = cfd_pkg::SLOT_W,
    parameter int IDX_W          = cfd_pkg::IDX_W,
    parameter int REG_W          = cfd_pkg::REG_W,
    parameter int PCM_W          = cfd_pkg::PCM_W,
    parameter int REG_SLOT       = cfd_pkg::REG_SLOT,
    parameter int FIRST_PCM_SLOT = cfd_pkg::FIRST_PCM_SLOT,
    parameter int NUM_PCM        = cfd_pkg::NUM_PCM
) (
    input  logic                            bit_clk,
    input  logic                            rst_n,
    input  logic                            sdata_in,
    input  logic [IDX_W-1:0]                idx_now,
    input  logic                            aligned,
    output logic [TAG_W-1:0]                tag_h,
    output logic [REG_W-1:0]                reg_h,
    output logic [NUM_PCM-1:0][PCM_W-1:0]   pcm_h
);
    localparam logic [IDX_W-1:0] TAG_END = IDX_W'(TAG_W - 1);
    localparam logic [IDX_W-1:0] REG_END = IDX_W'(TAG_W + SLOT_W * REG_SLOT - 1);

    logic [SLOT_W-2:0] shreg;
    logic [SLOT_W-1:0] word_now;

    // Slot word completed by the bit arriving in this cycle.
    assign word_now = {shreg, sdata_in};

    // Shift every sampled bit into the history register.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= word_now[SLOT_W-2:0];
    end

    // Store the tag once its last bit has been sampled.
    always_ff @(negedge bit_clk) begin
        if (!rst_n)                              tag_h <= '0;
        else if (aligned && idx_now == TAG_END)  tag_h <= word_now[TAG_W-1:0];
    end

    // Store the upper bits of the register readback slot.
    always_ff @(negedge bit_clk) begin
        if (!rst_n)                              reg_h <= '0;
        else if (aligned && idx_now == REG_END)  reg_h <= word_now[SLOT_W-1 -: REG_W];
    end

    // One capture register per audio slot.
    for (genvar g = 0; g < NUM_PCM; g++) begin : g_pcm
        localparam logic [IDX_W-1:0] PCM_END =
            IDX_W'(TAG_W + SLOT_W * (FIRST_PCM_SLOT + g) - 1);
        logic [PCM_W-1:0] pcm_q;

        // Keep the significant upper bits of this audio slot.
        always_ff @(negedge bit_clk) begin
            if (!rst_n)                              pcm_q <= '0;
            else if (aligned && idx_now == PCM_END)  pcm_q <= word_now[SLOT_W-1 -: PCM_W];
        end

        assign pcm_h[g] = pcm_q;
    end
endmodule

// File: rtl/cfd_frame_publish.sv
// Module: frame output stage.
// At the last bit of an aligned frame, copies the holding registers to the
// outputs together with valid flags decoded from the tag, and pulses done.
// Assumes the holding registers are settled before the last frame bit.
module cfd_frame_publish #(
    parameter int FRAME_W        = cfd_pkg::FRAME_W,
    parameter int TAG_W          = cfd_pkg::TAG_W,
    parameter int IDX_W          = cfd_pkg::IDX_W,
    parameter int REG_W          = cfd_pkg::REG_W,
    parameter int PCM_W          = cfd_pkg::PCM_W,
    parameter int REG_SLOT       = cfd_pkg::REG_SLOT,
    parameter int FIRST_PCM_SLOT = cfd_pkg::FIRST_PCM_SLOT,
    parameter int NUM_PCM        = cfd_pkg::NUM_PCM,
    parameter int READY_BIT      = cfd_pkg::READY_BIT
) (
    input  logic                            bit_clk,
    input  logic                            rst_n,
    input  logic [IDX_W-1:0]                idx_now,
    input  logic                            aligned,
    input  logic [TAG_W-1:0]                tag_h,
    input  logic [REG_W-1:0]                reg_h,
    input  logic [NUM_PCM-1:0][PCM_W-1:0]   pcm_h,
    output logic [TAG_W-1:0]                tag_o,
    output logic [REG_W-1:0]                reg_o,
    output logic                            reg_vld_o,
    output logic [NUM_PCM-1:0][PCM_W-1:0]   pcm_o,
    output logic [NUM_PCM-1:0]              pcm_vld_o,
    output logic                            done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic               publish;
    logic               reg_vld_d;
    logic [NUM_PCM-1:0] pcm_vld_d;

    // Publish when the final bit of an aligned frame is sampled.
    assign publish   = aligned && (idx_now == LAST_IDX);
    // Register slot valid only in a ready frame.
    assign reg_vld_d = tag_h[READY_BIT] & tag_h[READY_BIT - REG_SLOT];

    for (genvar g = 0; g < NUM_PCM; g++) begin : g_vld
        // Audio slot valid only in a ready frame.
        assign pcm_vld_d[g] = tag_h[READY_BIT] & tag_h[READY_BIT - (FIRST_PCM_SLOT + g)];
    end

    // Load the output words and raise the strobe for one cycle.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) begin
            tag_o     <= '0;
            reg_o     <= '0;
            reg_vld_o <= 1'b0;
            pcm_o     <= '0;
            pcm_vld_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= publish;
            if (publish) begin
                tag_o     <= tag_h;
                reg_o     <= reg_h;
                reg_vld_o <= reg_vld_d;
                pcm_o     <= pcm_h;
                pcm_vld_o <= pcm_vld_d;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
        done_o |=> !done_o);                                          // R7
    AST_DONE_AT_LAST_BIT: assert property (@(negedge bit_clk) disable iff (!rst_n)
        done_o |-> ($past(idx_now) == LAST_IDX && $past(aligned)));    // R7
    AST_OUTPUTS_HELD: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !done_o |-> ($stable(tag_o) && $stable(reg_o) && $stable(pcm_o)
                     && $stable(reg_vld_o) && $stable(pcm_vld_o)));     // R8
endmodule

// File: rtl/codec_frame_deser.sv
// Module: codec serial frame receiver (top).
// Deserializes the codec's serial stream on the falling bit-clock edge,
// aligned to sync rising edges, and publishes tag, register readback word
// and two audio samples once per frame. Assumes sync and data change away
// from the falling edge and reset is synchronous to the same edge.
module codec_frame_deser (
    input  logic        bit_clk,
    input  logic        rst_n,
    input  logic        sync_in,
    input  logic        sdata_in,
    output logic [15:0] frame_tag,
    output logic [15:0] reg_data,
    output logic        reg_valid,
    output logic [17:0] left_pcm,
    output logic        left_valid,
    output logic [17:0] right_pcm,
    output logic        right_valid,
    output logic        frame_done
);
    import cfd_pkg::*;

    logic [IDX_W-1:0]              idx_now;
    logic                          aligned;
    logic [TAG_W-1:0]              tag_h;
    logic [REG_W-1:0]              reg_h;
    logic [NUM_PCM-1:0][PCM_W-1:0] pcm_h;
    logic [NUM_PCM-1:0][PCM_W-1:0] pcm_o;
    logic [NUM_PCM-1:0]            pcm_vld;

    cfd_bit_index u_index (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .idx_now (idx_now),
        .aligned (aligned)
    );

    cfd_slot_capture u_capture (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .sdata_in (sdata_in),
        .idx_now  (idx_now),
        .aligned  (aligned),
        .tag_h    (tag_h),
        .reg_h    (reg_h),
        .pcm_h    (pcm_h)
    );

    cfd_frame_publish u_publish (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .idx_now   (idx_now),
        .aligned   (aligned),
        .tag_h     (tag_h),
        .reg_h     (reg_h),
        .pcm_h     (pcm_h),
        .tag_o     (frame_tag),
        .reg_o     (reg_data),
        .reg_vld_o (reg_valid),
        .pcm_o     (pcm_o),
        .pcm_vld_o (pcm_vld),
        .done_o    (frame_done)
    );

    assign left_pcm    = pcm_o[0];
    assign right_pcm   = pcm_o[1];
    assign left_valid  = pcm_vld[0];
    assign right_valid = pcm_vld[1];

    AST_VALID_NEEDS_READY: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (left_valid || right_valid || reg_valid) |-> frame_tag[15]);   // R6
    AST_NO_STROBE_UNALIGNED: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_done |-> $past(aligned));                               // R10
endmodule

// File: tb/test_codec_frame_deser.sv
module test_codec_frame_deser;
    localparam time CLK_PERIOD = 10ns;

    logic        bit_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        sync_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [15:0] frame_tag, reg_data;
    logic        reg_valid, left_valid, right_valid, frame_done;
    logic [17:0] left_pcm, right_pcm;

    int n_checks = 0;
    int n_err    = 0;
    int n_done   = 0;

    logic [15:0] held_tag = '0;
    logic [17:0] held_left = '0;

    codec_frame_deser i_codec_frame_deser (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync_in(sync_in), .sdata_in(sdata_in),
        .frame_tag(frame_tag), .reg_data(reg_data), .reg_valid(reg_valid),
        .left_pcm(left_pcm), .left_valid(left_valid),
        .right_pcm(right_pcm), .right_valid(right_valid),
        .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    // Count strobe cycles just after each falling edge.
    always @(negedge bit_clk) begin
        #1;
        if (frame_done === 1'b1) n_done++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive nbits of a frame, one bit per period, changes after the rising edge.
    task automatic send_frame(input logic [15:0] tag, input logic [19:0] s2,
                              input logic [19:0] s3, input logic [19:0] s4,
                              input int nbits, input bit use_sync);
        logic [255:0] f;
        f = {tag, 20'h0, s2, s3, s4, 160'h0};
        for (int i = 0; i < nbits; i++) begin
            @(posedge bit_clk);
            #1;
            sync_in  = use_sync && (i < 16);
            sdata_in = f[255 - i];
            if (i == 100) begin
                chk("R8", "tag held mid-frame", 32'(frame_tag), 32'(held_tag));
                chk("R8", "left held mid-frame", 32'(left_pcm), 32'(held_left));
                chk("R7", "strobe low mid-frame", 32'(frame_done), 32'd0);
            end
        end
    endtask

    // Check outputs just after the falling edge that sampled bit 255.
    task automatic expect_frame(input logic [15:0] tag, input logic [19:0] s2,
                                input logic [19:0] s3, input logic [19:0] s4,
                                input string req);
        @(negedge bit_clk);
        #1;
        chk("R7", {req, " strobe"}, 32'(frame_done), 32'd1);
        chk("R3", {req, " tag"}, 32'(frame_tag), 32'(tag));
        chk("R4", {req, " reg data"}, 32'(reg_data), 32'(s2[19:4]));
        chk("R5", {req, " left"}, 32'(left_pcm), 32'(s3[19:2]));
        chk("R5", {req, " right"}, 32'(right_pcm), 32'(s4[19:2]));
        chk("R6", {req, " reg valid"}, 32'(reg_valid), 32'(tag[15] & tag[13]));
        chk("R6", {req, " left valid"}, 32'(left_valid), 32'(tag[15] & tag[12]));
        chk("R6", {req, " right valid"}, 32'(right_valid), 32'(tag[15] & tag[11]));
        held_tag  = tag;
        held_left = s3[19:2];
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int d0;
        logic [15:0] t;
        logic [19:0] a, b, c;

        // R1: reset state.
        repeat (5) @(posedge bit_clk);
        #1;
        chk("R1", "tag in reset", 32'(frame_tag), 32'd0);
        chk("R1", "strobe in reset", 32'(frame_done), 32'd0);
        rst_n = 1'b1;
        @(posedge bit_clk);
        #1;
        chk("R1", "left after reset", 32'(left_pcm), 32'd0);
        chk("R1", "valids after reset", 32'({reg_valid, left_valid, right_valid}), 32'd0);

        // R10: data without sync never completes a frame.
        for (int i = 0; i < 300; i++) begin
            @(posedge bit_clk);
            #1;
            sdata_in = i[0] ^ i[3];
        end
        chk("R10", "no strobe before sync", 32'(n_done), 32'd0);
        chk("R10", "tag untouched before sync", 32'(frame_tag), 32'd0);

        // R2-R7: sweep all ready/slot-valid combinations.
        for (int k = 0; k < 16; k++) begin
            t = 16'h4000 | 16'(k[3]) << 15 | 16'(k[2]) << 13 | 16'(k[1]) << 12
                | 16'(k[0]) << 11 | 16'(k * 37 + 5) & 16'h07FF;
            a = {16'(k * 16'h1357) ^ 16'hA5C3, 4'(k)};
            b = 20'(k * 20'h0B3D7 + 20'h80001);
            c = ~b ^ 20'(k << 3);
            d0 = n_done;
            send_frame(t, a, b, c, 256, 1'b1);
            expect_frame(t, a, b, c, "R2 sweep");
            chk("R2", "one strobe per frame", 32'(n_done - d0), 32'd1);
        end

        // R5: extreme samples with the dropped low bits set.
        send_frame(16'hF800, 20'hFFFFF, {18'h1FFFF, 2'b11}, {18'h20000, 2'b11}, 256, 1'b1);
        expect_frame(16'hF800, 20'hFFFFF, {18'h1FFFF, 2'b11}, {18'h20000, 2'b11}, "R5 extremes");
        send_frame(16'hF800, 20'h0000F, {18'h20000, 2'b01}, {18'h1FFFF, 2'b10}, 256, 1'b1);
        expect_frame(16'hF800, 20'h0000F, {18'h20000, 2'b01}, {18'h1FFFF, 2'b10}, "R5 extremes");

        // R9: truncated frame is dropped, following frame decodes.
        d0 = n_done;
        send_frame(16'hFFFF, 20'h12345, 20'h54321, 20'hABCDE, 100, 1'b1);
        send_frame(16'h9000, 20'hCAFE1, 20'h3C3C3, 20'hC3C3C, 256, 1'b1);
        expect_frame(16'h9000, 20'hCAFE1, 20'h3C3C3, 20'hC3C3C, "R9 realign");
        chk("R9", "truncated frame gives no strobe", 32'(n_done - d0), 32'd1);

        // R11: a frame without sync is decoded by wrap-around.
        send_frame(16'hB800, 20'h0F0F0, 20'h11111, 20'h22222, 256, 1'b1);
        expect_frame(16'hB800, 20'h0F0F0, 20'h11111, 20'h22222, "R11 first");
        send_frame(16'hD000, 20'h76543, 20'h2AAAA, 20'hD5555, 256, 1'b0);
        expect_frame(16'hD000, 20'h76543, 20'h2AAAA, 20'hD5555, "R11 free-run");

        // R7: strobe drops after one cycle.
        @(negedge bit_clk);
        #1;
        chk("R7", "strobe one cycle", 32'(frame_done), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule